// File: doc/BRIEF.md
# ADC Event Flag and Interrupt Controller

This block keeps the status flags a converter raises while it works through a regular channel group and an injected channel group. It also merges those flags into one interrupt line. The conversion engine sends one-cycle strobes for five kinds of event:

- end of a sampling phase;
- a new regular result;
- the last regular result of a sequence;
- a new injected result in one of four injected slots;
- the end of an injected sequence.

Software works through a small register bus. It reads the flags on `flags_o` and clears them by writing ones to the status address. It can also clear a data-ready flag by reading the data address that holds that result. The data values themselves are held elsewhere. This block only sees the read strobe and its address.

Each flag has an enable bit in an enable register at the same bit position. The interrupt line is high while any enabled flag is set. It is registered, so it follows the flag state one cycle later.

Top module: `adc_evt_irq_ctrl`

## Requirements
- R1: After reset, all five flags read 0, the enable register is 0 and `irq_o` is 0.
- R2: Bit 0 (end of sampling) sets on `smp_done_i`. It clears only when 1 is written to bit 0 at status address 0. Reads of any data address leave it set.
- R3: Bit 1 (regular data ready) sets on `reg_rdy_i`. It clears when 1 is written to bit 1 at address 0, or on a bus read of the regular data address 2.
- R4: Bit 2 (end of regular sequence) sets on `reg_seq_last_i`. It clears only when 1 is written to bit 2 at address 0. A read of address 2 leaves it set.
- R5: Bit 3 (injected data ready) sets on `inj_rdy_i` and records `inj_slot_i` as its slot. It clears when 1 is written to bit 3 at address 0, or on a read of address 4+slot for the recorded slot. Injected slots 0 to 3 sit at addresses 4 to 7.
- R6: A read of an injected address other than the one for the recorded slot leaves bit 3 set.
- R7: Bit 4 (end of injected sequence) sets on `inj_seq_done_i`. It clears only when 1 is written to bit 4 at address 0.
- R8: The following never change the flags:
  - writing 0 to a status bit;
  - any write to the enable address 1;
  - a write to any data address.
- R9: When a set strobe and a clear request reach the same flag in the same cycle, the flag ends up set.
- R10: The enable register at address 1 uses the flag bit positions. `irq_o` equals the OR of (flag AND enable), taken from the state one cycle earlier.
- R11: All flags update on the clock edge that samples the strobe or the bus request. The new value is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_done_i | input | 1 | End-of-sampling strobe (regular conversions) |
| reg_rdy_i | input | 1 | New regular result strobe |
| reg_seq_last_i | input | 1 | Last regular result of a sequence |
| inj_rdy_i | input | 1 | New injected result strobe |
| inj_slot_i | input | 2 | Injected slot that took the result |
| inj_seq_done_i | input | 1 | Injected sequence complete |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 4 | Bus word address |
| bus_wdata_i | input | 8 | Bus write data |
| flags_o | output | 5 | Status flags |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Flag results are due on the edge that samples the strobe or bus request. The interrupt follows one edge after that, because its register samples the flag and enable registers.

The bench drives inputs just after a falling edge. At the rising edge it updates its model from those inputs. It compares `flags_o` and `irq_o` at the next falling edge, which keeps every comparison half a cycle clear of the edge that moved them.

The interrupt model is computed from the model state before each update, which gives the one-cycle lag.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FLG_SMP   = 0;
  localparam int FLG_RDAT  = 1;
  localparam int FLG_RSEQ  = 2;
  localparam int FLG_IDAT  = 3;
  localparam int FLG_ISEQ  = 4;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r9_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r11_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r8_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/inj_slot_track.sv
module inj_slot_track #(
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              rd_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              hit_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (load_i) slot_q <= slot_i;
  end

  assign slot_o = slot_q;
  assign hit_o  = rd_i && (rd_slot_i == slot_q);

  a_r5_slot_load : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slot_o == $past(slot_i)));
  a_r6_slot_keep : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(slot_o));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] ien_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & ien_i);
  end

  assign irq_o = irq_q;

  a_r10_irq_lag : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(flags_i & ien_i))));
endmodule

// File: rtl/adc_evt_irq_ctrl.sv
module adc_evt_irq_ctrl
  import adc_evt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int INJ_SLOTS  = 4,
  parameter int A_STATUS   = 0,
  parameter int A_IEN      = 1,
  parameter int A_RDATA    = 2,
  parameter int A_INJ_BASE = 4,
  localparam int SLOT_W    = $clog2(INJ_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_done_i,
  input  logic                 reg_rdy_i,
  input  logic                 reg_seq_last_i,
  input  logic                 inj_rdy_i,
  input  logic [SLOT_W-1:0]    inj_slot_i,
  input  logic                 inj_seq_done_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  localparam logic [ADDR_W-1:0] ADR_ST  = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] ADR_IE  = ADDR_W'(A_IEN);
  localparam logic [ADDR_W-1:0] ADR_RD  = ADDR_W'(A_RDATA);
  localparam logic [ADDR_W-1:0] ADR_INJ = ADDR_W'(A_INJ_BASE);
  localparam logic [ADDR_W-1:0] ADR_END = ADDR_W'(A_INJ_BASE + INJ_SLOTS);

  logic              wr_status, wr_ien, rd_rdata, rd_inj, inj_hit;
  logic [ADDR_W-1:0] inj_off;
  logic [SLOT_W-1:0] rd_slot, cur_slot;
  flag_vec_t         set_v, clr_v, flag_v, ien_q;

  assign wr_status = bus_wr_i && (bus_addr_i == ADR_ST);
  assign wr_ien    = bus_wr_i && (bus_addr_i == ADR_IE);
  assign rd_rdata  = bus_rd_i && (bus_addr_i == ADR_RD);
  assign rd_inj    = bus_rd_i && (bus_addr_i >= ADR_INJ) && (bus_addr_i < ADR_END);
  assign inj_off   = bus_addr_i - ADR_INJ;
  assign rd_slot   = inj_off[SLOT_W-1:0];

  inj_slot_track #(.SLOTS(INJ_SLOTS)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (inj_rdy_i),
    .slot_i    (inj_slot_i),
    .rd_i      (rd_inj),
    .rd_slot_i (rd_slot),
    .slot_o    (cur_slot),
    .hit_o     (inj_hit)
  );

  always_comb begin
    set_v           = '0;
    set_v[FLG_SMP]  = smp_done_i;
    set_v[FLG_RDAT] = reg_rdy_i;
    set_v[FLG_RSEQ] = reg_seq_last_i;
    set_v[FLG_IDAT] = inj_rdy_i;
    set_v[FLG_ISEQ] = inj_seq_done_i;

    clr_v = wr_status ? bus_wdata_i[NUM_FLAGS-1:0] : '0;
    // clear-on-read side effects for data-ready flags
    if (rd_rdata) clr_v[FLG_RDAT] = 1'b1;
    if (inj_hit)  clr_v[FLG_IDAT] = 1'b1;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    evt_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flag_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata_i[NUM_FLAGS-1:0];
  end

  irq_merge #(.N(NUM_FLAGS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flag_v),
    .ien_i   (ien_q),
    .irq_o   (irq_o)
  );

  assign flags_o = flag_v;

  a_r6_other_slot : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLG_IDAT] && rd_inj && (rd_slot != cur_slot) && !wr_status)
      |=> flags_o[FLG_IDAT]);
  a_r8_ien_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien && !(|set_v) && !bus_rd_i) |=> $stable(flags_o));
  a_r4_rseq_no_read_clr : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLG_RSEQ] && !bus_wr_i) |=> flags_o[FLG_RSEQ]);
  a_r2_smp_no_read_clr : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLG_SMP] && !bus_wr_i) |=> flags_o[FLG_SMP]);
endmodule

// File: tb/adc_evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_evt_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_done_i = 0, reg_rdy_i = 0, reg_seq_last_i = 0;
  logic       inj_rdy_i = 0, inj_seq_done_i = 0;
  logic [1:0] inj_slot_i = '0;
  logic       bus_wr_i = 0, bus_rd_i = 0;
  logic [3:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [4:0] flags_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag_s = "R1";

  logic [4:0] fl_m = '0, ien_m = '0;
  logic [1:0] slot_m = '0;
  logic       irq_m = 1'b0;

  always #2 clk_i = ~clk_i;

  adc_evt_irq_ctrl u_dut (
    .clk_i, .rst_ni, .smp_done_i, .reg_rdy_i, .reg_seq_last_i,
    .inj_rdy_i, .inj_slot_i, .inj_seq_done_i,
    .bus_wr_i, .bus_rd_i, .bus_addr_i, .bus_wdata_i,
    .flags_o, .irq_o
  );

  function automatic logic [4:0] clr_of(logic wr, logic rd, logic [3:0] a,
                                        logic [7:0] d, logic [1:0] s);
    logic [4:0] c = '0;
    if (wr && a == 4'd0) c = d[4:0];
    if (rd && a == 4'd2) c[1] = 1'b1;
    if (rd && a >= 4'd4 && a <= 4'd7 && a[1:0] == s) c[3] = 1'b1;
    return c;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    smp_done_i = 0; reg_rdy_i = 0; reg_seq_last_i = 0;
    inj_rdy_i = 0; inj_seq_done_i = 0; inj_slot_i = '0;
    bus_wr_i = 0; bus_rd_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
  endtask

  task automatic cyc();
    logic [4:0] s, c;
    @(posedge clk_i);
    irq_m = |(fl_m & ien_m);
    s = {inj_seq_done_i, inj_rdy_i, reg_seq_last_i, reg_rdy_i, smp_done_i};
    c = clr_of(bus_wr_i, bus_rd_i, bus_addr_i, bus_wdata_i, slot_m);
    fl_m = s | (fl_m & ~c);
    if (inj_rdy_i) slot_m = inj_slot_i;
    if (bus_wr_i && bus_addr_i == 4'd1) ien_m = bus_wdata_i[4:0];
    @(negedge clk_i);
    check({tag_s, " flags"}, flags_o, fl_m);
    check({tag_s, "/R10 irq"}, {4'b0, irq_o}, {4'b0, irq_m});
    idle();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d; cyc();
  endtask

  task automatic rd(logic [3:0] a);
    bus_rd_i = 1; bus_addr_i = a; cyc();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a0c));
    repeat (3) @(negedge clk_i);
    tag_s = "R1";
    check("R1 flags", flags_o, 5'b0);
    check("R1 irq", {4'b0, irq_o}, 5'b0);
    rst_ni = 1'b1;
    cyc();

    tag_s = "R2";  smp_done_i = 1; cyc(); check("R2 set", flags_o, 5'b00001);
    rd(4'd2); rd(4'd5); wr(4'd0, 8'h01);
    tag_s = "R3";  reg_rdy_i = 1; cyc(); check("R3 set", flags_o, 5'b00010);
    rd(4'd2); check("R3 read clr", flags_o, 5'b0);
    reg_rdy_i = 1; cyc(); wr(4'd0, 8'h02);
    tag_s = "R4";  reg_seq_last_i = 1; cyc(); rd(4'd2);
    check("R4 read keeps", flags_o, 5'b00100); wr(4'd0, 8'h04);
    tag_s = "R5";  inj_rdy_i = 1; inj_slot_i = 2'd2; cyc(); rd(4'd6);
    check("R5 read clr", flags_o, 5'b0);
    tag_s = "R6";  inj_rdy_i = 1; inj_slot_i = 2'd1; cyc(); rd(4'd4); rd(4'd7);
    check("R6 keeps", flags_o, 5'b01000); wr(4'd0, 8'h08);
    tag_s = "R7";  inj_seq_done_i = 1; cyc(); rd(4'd4); rd(4'd2);
    check("R7 keeps", flags_o, 5'b10000); wr(4'd0, 8'h10);
    check("R7 clr", flags_o, 5'b0);
    tag_s = "R8";
    smp_done_i = 1; reg_rdy_i = 1; reg_seq_last_i = 1; inj_rdy_i = 1;
    inj_seq_done_i = 1; cyc();
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'hFF); wr(4'd5, 8'hFF);
    check("R8 all set", flags_o, 5'b11111);
    wr(4'd0, 8'h1F);
    tag_s = "R9";
    reg_rdy_i = 1; bus_rd_i = 1; bus_addr_i = 4'd2; cyc();
    check("R9 read vs set", flags_o, 5'b00010);
    smp_done_i = 1; bus_wr_i = 1; bus_wdata_i = 8'h1F; cyc();
    check("R9 w1c vs set", flags_o, 5'b00001);
    wr(4'd0, 8'h1F);
    tag_s = "R10";
    wr(4'd1, 8'h02); smp_done_i = 1; cyc(); cyc();
    check("R10 masked", {4'b0, irq_o}, 5'b0);
    reg_rdy_i = 1; cyc();
    check("R10 lag", {4'b0, irq_o}, 5'b0);
    cyc();
    check("R10 raised", {4'b0, irq_o}, 5'b1);
    rd(4'd2); cyc();
    check("R10 dropped", {4'b0, irq_o}, 5'b0);

    tag_s = "R11";
    for (int i = 0; i < 4000; i++) begin
      smp_done_i     = ($urandom % 8) == 0;
      reg_rdy_i      = ($urandom % 6) == 0;
      reg_seq_last_i = ($urandom % 12) == 0;
      inj_rdy_i      = ($urandom % 6) == 0;
      inj_slot_i     = 2'($urandom);
      inj_seq_done_i = ($urandom % 12) == 0;
      case ($urandom % 5)
        0: begin bus_wr_i = 1; bus_addr_i = 4'($urandom % 8); bus_wdata_i = 8'($urandom); end
        1, 2: begin bus_rd_i = 1; bus_addr_i = 4'($urandom); end
        default: ;
      endcase
      cyc();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule